// File: doc/BRIEF.md
# Kernel Workgroup Dispatch Sequencer

This block takes in one kernel launch descriptor at a time and then releases that kernel's workgroups one per strobe. The descriptor gives the grid extent and the workgroup extent in each of three dimensions. It also gives the vector and scalar register counts as written, the coarse granule fields for both counts, a generation select bit and a major architecture version. When the descriptor is accepted, the block resolves the final register budget. It also computes how many workgroups fit along each axis and the total number of workgroups for the kernel.

After a descriptor is accepted, each dispatch strobe moves a three-dimensional workgroup coordinate and a flat workgroup index forward. The X coordinate advances fastest and carries into Y and then into Z. Each carry test multiplies the new coordinate by the workgroup extent and compares the result with the grid extent. When Z runs past its extent, a grid-finished flag is raised. Separate completion strobes count the workgroups that have retired. A new descriptor can be accepted only once every workgroup of the current kernel has reported back. A descriptor with an illegal version or a zero workgroup extent is refused: the block reports an error and stays idle.

Top module: `wgd_sequencer`

## Requirements
- R1: When `desc_vreg` is zero, `vreg_count` becomes (`desc_vgran` + 1) × 8 if `desc_newgen` is 1, or (`desc_vgran` + 1) × 4 if it is 0. Otherwise `vreg_count` equals `desc_vreg`.
- R2: `sreg_count` equals `desc_sreg` unless `desc_sreg` is zero or all ones. In those two cases the count is derived from `desc_sgran` as R3 describes.
- R3: The derived scalar count is (`desc_sgran` + 1) × 8 when `desc_major` is 0 or 8, and ((`desc_sgran` + 1) × 16) / 2 when `desc_major` is 9.
- R4: A descriptor whose `desc_major` is not 0, 8 or 9 sets `cfg_error`, and the block does not enter the running state.
- R5: `wg_cnt_x/y/z` equal the ceiling of grid extent divided by workgroup extent in that axis. `wg_cnt_total` is the product of the three.
- R6: Each dispatch strobe taken while running and not finished adds 1 to `wg_id_x` and to `wg_global`. Both values are visible on the next cycle.
- R7: When (new X) × `desc_wg_x` ≥ `desc_grid_x`, X returns to 0 and Y advances. The same test on Y returns Y to 0 and advances Z.
- R8: When a carry makes (new Z) × `desc_wg_z` ≥ `desc_grid_z`, `grid_done` goes to 1. After exactly `wg_cnt_total` strobes, X and Y read 0 and Z reads `wg_cnt_z`.
- R9: Accepting any descriptor clears the three coordinates, `wg_global`, `wg_done_cnt` and `grid_done`.
- R10: A dispatch strobe while `grid_done` is 1, or while the block is not running, leaves every coordinate and `wg_global` unchanged.
- R11: `desc_ready` is 0 while running with `wg_done_cnt` below `wg_cnt_total`. A descriptor offered during that time is ignored.
- R12: A descriptor with any workgroup extent of zero sets `cfg_error` and leaves the block idle with `desc_ready` at 1. A later legal descriptor clears `cfg_error`.
- R13: Each completion strobe taken while running adds 1 to `wg_done_cnt`, which stops at `wg_cnt_total`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor can be taken |
| desc_grid_x | input | 32 | Grid extent, X |
| desc_grid_y | input | 32 | Grid extent, Y |
| desc_grid_z | input | 32 | Grid extent, Z |
| desc_wg_x | input | 32 | Workgroup extent, X |
| desc_wg_y | input | 32 | Workgroup extent, Y |
| desc_wg_z | input | 32 | Workgroup extent, Z |
| desc_vreg | input | 16 | Explicit vector register count, 0 = derive |
| desc_sreg | input | 16 | Explicit scalar register count, 0 or all ones = derive |
| desc_vgran | input | 6 | Vector register granule field |
| desc_sgran | input | 4 | Scalar register granule field |
| desc_newgen | input | 1 | Selects the ×8 vector granule rule |
| desc_major | input | 8 | Major architecture version |
| disp_strobe | input | 1 | Hand out one workgroup |
| done_strobe | input | 1 | One workgroup retired |
| vreg_count | output | 16 | Resolved vector registers per work-item |
| sreg_count | output | 16 | Resolved scalar registers per wavefront |
| wg_cnt_x | output | 32 | Workgroups along X |
| wg_cnt_y | output | 32 | Workgroups along Y |
| wg_cnt_z | output | 32 | Workgroups along Z |
| wg_cnt_total | output | 32 | Total workgroups |
| wg_id_x | output | 32 | Current X coordinate |
| wg_id_y | output | 32 | Current Y coordinate |
| wg_id_z | output | 32 | Current Z coordinate |
| wg_global | output | 32 | Flat workgroup index |
| wg_done_cnt | output | 32 | Retired workgroup count |
| grid_done | output | 1 | All workgroups handed out |
| cfg_error | output | 1 | Last descriptor was refused |

## Verification
A wrong carry decision shows on the coordinate outputs in the first cycle after the strobe that should have wrapped. It then shifts every later coordinate, and it moves `grid_done` away from strobe number `wg_cnt_total`. A wrong granule rule or workgroup count shows on the resolved outputs in the cycle right after acceptance. A faulty completion counter shows up as `desc_ready` rising one or more strobes too early or too late. The bench walks every coordinate of each accepted kernel, checking each one against indices it derives itself, so any of these faults is caught within one cycle.

// File: rtl/wgd_pkg.sv
package wgd_pkg;

    localparam int DIMS    = 3;
    localparam int EXT_W   = 32;
    localparam int MAJ_W   = 8;

    typedef struct packed {
        logic [EXT_W-1:0] grid;
        logic [EXT_W-1:0] wg;
    } dim_cfg_t;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;

    function automatic logic major_is_legal(input logic [MAJ_W-1:0] mj);
        return (mj == MAJ_W'(0)) || (mj == MAJ_W'(8)) || (mj == MAJ_W'(9));
    endfunction

    function automatic logic [EXT_W-1:0] ceil_div(input logic [EXT_W-1:0] num,
                                                  input logic [EXT_W-1:0] den);
        if (num == '0 || den == '0)
            return '0;
        return ((num - EXT_W'(1)) / den) + EXT_W'(1);
    endfunction

endpackage

// File: rtl/wgd_reg_derive.sv
module wgd_reg_derive
    import wgd_pkg::*;
#(
    parameter int VREG_W  = 16,
    parameter int SREG_W  = 16,
    parameter int VGRAN_W = 6,
    parameter int SGRAN_W = 4
) (
    input  logic [VREG_W-1:0]  vreg_in,
    input  logic [SREG_W-1:0]  sreg_in,
    input  logic [VGRAN_W-1:0] vgran,
    input  logic [SGRAN_W-1:0] sgran,
    input  logic               newgen,
    input  logic [MAJ_W-1:0]   major,
    output logic [VREG_W-1:0]  vreg_out,
    output logic [SREG_W-1:0]  sreg_out,
    output logic               bad_major
);
    localparam logic [SREG_W-1:0] SREG_ALL1 = '1;

    logic [VREG_W-1:0] v_units;
    logic [SREG_W-1:0] s_units;
    logic [SREG_W-1:0] s_derived;

    always_comb begin
        v_units   = VREG_W'(vgran) + VREG_W'(1);
        s_units   = SREG_W'(sgran) + SREG_W'(1);
        bad_major = !major_is_legal(major);

        if (vreg_in != '0)
            vreg_out = vreg_in;
        else if (newgen)
            vreg_out = v_units << 3;
        else
            vreg_out = v_units << 2;

        if (major == MAJ_W'(9))
            s_derived = (s_units << 4) >> 1;
        else if (!bad_major)
            s_derived = s_units << 3;
        else
            s_derived = '0;

        if (sreg_in == '0 || sreg_in == SREG_ALL1)
            sreg_out = s_derived;
        else
            sreg_out = sreg_in;
    end
endmodule

// File: rtl/wgd_dim_count.sv
module wgd_dim_count
    import wgd_pkg::*;
(
    input  dim_cfg_t         cfg,
    output logic [EXT_W-1:0] count,
    output logic             zero_wg
);
    always_comb begin
        zero_wg = (cfg.wg == '0);
        count   = ceil_div(cfg.grid, cfg.wg);
    end
endmodule

// File: rtl/wgd_id_walker.sv
module wgd_id_walker
    import wgd_pkg::*;
#(
    parameter int GID_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             adv,
    input  dim_cfg_t         cfg [DIMS],
    output logic [EXT_W-1:0] ids [DIMS],
    output logic [GID_W-1:0] gid,
    output logic             fin
);
    localparam int PROD_W = 2 * EXT_W;

    logic [EXT_W-1:0] ids_nx [DIMS];
    logic             fin_nx;
    logic             carry;
    logic [PROD_W-1:0] prod [DIMS];

    always_comb begin
        carry  = 1'b1;
        fin_nx = 1'b0;
        for (int d = 0; d < DIMS; d++) begin
            ids_nx[d] = ids[d];
            prod[d]   = '0;
            if (carry) begin
                ids_nx[d] = ids[d] + EXT_W'(1);
                prod[d]   = PROD_W'(ids_nx[d]) * PROD_W'(cfg[d].wg);
                if (prod[d] >= PROD_W'(cfg[d].grid)) begin
                    if (d == DIMS - 1)
                        fin_nx = 1'b1;
                    else
                        ids_nx[d] = '0;
                end else begin
                    carry = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || start) begin
            for (int d = 0; d < DIMS; d++)
                ids[d] <= '0;
            gid <= '0;
            fin <= 1'b0;
        end else if (adv && !fin) begin
            for (int d = 0; d < DIMS; d++)
                ids[d] <= ids_nx[d];
            gid <= gid + GID_W'(1);
            fin <= fin_nx;
        end
    end

    p_gid_step_r6: assert property (@(posedge clk) disable iff (rst)
        (adv && !fin && !start) |=> (gid == $past(gid) + GID_W'(1)));

    p_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        ((fin || !adv) && !start) |=> ($stable(gid) && $stable(ids[0])));

    p_x_inrange_r7: assert property (@(posedge clk) disable iff (rst)
        (!fin && cfg[0].wg != '0) |->
        (ids[0] == '0 || PROD_W'(ids[0]) * PROD_W'(cfg[0].wg) < PROD_W'(cfg[0].grid)));
endmodule

// File: rtl/wgd_sequencer.sv
module wgd_sequencer
    import wgd_pkg::*;
#(
    parameter int VREG_W  = 16,
    parameter int SREG_W  = 16,
    parameter int VGRAN_W = 6,
    parameter int SGRAN_W = 4,
    parameter int TOT_W   = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               desc_valid,
    output logic               desc_ready,
    input  logic [EXT_W-1:0]   desc_grid_x,
    input  logic [EXT_W-1:0]   desc_grid_y,
    input  logic [EXT_W-1:0]   desc_grid_z,
    input  logic [EXT_W-1:0]   desc_wg_x,
    input  logic [EXT_W-1:0]   desc_wg_y,
    input  logic [EXT_W-1:0]   desc_wg_z,
    input  logic [VREG_W-1:0]  desc_vreg,
    input  logic [SREG_W-1:0]  desc_sreg,
    input  logic [VGRAN_W-1:0] desc_vgran,
    input  logic [SGRAN_W-1:0] desc_sgran,
    input  logic               desc_newgen,
    input  logic [MAJ_W-1:0]   desc_major,
    input  logic               disp_strobe,
    input  logic               done_strobe,
    output logic [VREG_W-1:0]  vreg_count,
    output logic [SREG_W-1:0]  sreg_count,
    output logic [EXT_W-1:0]   wg_cnt_x,
    output logic [EXT_W-1:0]   wg_cnt_y,
    output logic [EXT_W-1:0]   wg_cnt_z,
    output logic [TOT_W-1:0]   wg_cnt_total,
    output logic [EXT_W-1:0]   wg_id_x,
    output logic [EXT_W-1:0]   wg_id_y,
    output logic [EXT_W-1:0]   wg_id_z,
    output logic [TOT_W-1:0]   wg_global,
    output logic [TOT_W-1:0]   wg_done_cnt,
    output logic               grid_done,
    output logic               cfg_error
);
    seq_state_t        state_q;
    dim_cfg_t          in_cfg  [DIMS];
    dim_cfg_t          cfg_q   [DIMS];
    logic [EXT_W-1:0]  in_cnt  [DIMS];
    logic [EXT_W-1:0]  cnt_q   [DIMS];
    logic [DIMS-1:0]   in_zero;
    logic [EXT_W-1:0]  ids     [DIMS];
    logic [VREG_W-1:0] vreg_nx;
    logic [SREG_W-1:0] sreg_nx;
    logic              bad_major;
    logic              accept;
    logic              refuse;
    logic              adv;
    logic              running;

    always_comb begin
        in_cfg[0] = '{grid: desc_grid_x, wg: desc_wg_x};
        in_cfg[1] = '{grid: desc_grid_y, wg: desc_wg_y};
        in_cfg[2] = '{grid: desc_grid_z, wg: desc_wg_z};
    end

    wgd_reg_derive #(
        .VREG_W (VREG_W),
        .SREG_W (SREG_W),
        .VGRAN_W(VGRAN_W),
        .SGRAN_W(SGRAN_W)
    ) u_derive (
        .vreg_in  (desc_vreg),
        .sreg_in  (desc_sreg),
        .vgran    (desc_vgran),
        .sgran    (desc_sgran),
        .newgen   (desc_newgen),
        .major    (desc_major),
        .vreg_out (vreg_nx),
        .sreg_out (sreg_nx),
        .bad_major(bad_major)
    );

    for (genvar d = 0; d < DIMS; d++) begin : g_dim
        wgd_dim_count u_cnt (
            .cfg    (in_cfg[d]),
            .count  (in_cnt[d]),
            .zero_wg(in_zero[d])
        );
    end

    assign running      = (state_q == SEQ_RUN);
    assign wg_cnt_total = TOT_W'(cnt_q[0]) * TOT_W'(cnt_q[1]) * TOT_W'(cnt_q[2]);
    assign desc_ready   = !running || (wg_done_cnt == wg_cnt_total);
    assign accept       = desc_valid && desc_ready;
    assign refuse       = bad_major || (|in_zero);
    assign adv          = disp_strobe && running;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= SEQ_IDLE;
            cfg_error   <= 1'b0;
            wg_done_cnt <= '0;
            vreg_count  <= '0;
            sreg_count  <= '0;
            for (int d = 0; d < DIMS; d++) begin
                cfg_q[d] <= '0;
                cnt_q[d] <= '0;
            end
        end else if (accept) begin
            wg_done_cnt <= '0;
            cfg_error   <= refuse;
            if (refuse) begin
                state_q <= SEQ_IDLE;
            end else begin
                state_q    <= SEQ_RUN;
                vreg_count <= vreg_nx;
                sreg_count <= sreg_nx;
                for (int d = 0; d < DIMS; d++) begin
                    cfg_q[d] <= in_cfg[d];
                    cnt_q[d] <= in_cnt[d];
                end
            end
        end else if (done_strobe && running && wg_done_cnt != wg_cnt_total) begin
            wg_done_cnt <= wg_done_cnt + TOT_W'(1);
        end
    end

    wgd_id_walker #(.GID_W(TOT_W)) u_walk (
        .clk  (clk),
        .rst  (rst),
        .start(accept),
        .adv  (adv),
        .cfg  (cfg_q),
        .ids  (ids),
        .gid  (wg_global),
        .fin  (grid_done)
    );

    assign wg_cnt_x = cnt_q[0];
    assign wg_cnt_y = cnt_q[1];
    assign wg_cnt_z = cnt_q[2];
    assign wg_id_x  = ids[0];
    assign wg_id_y  = ids[1];
    assign wg_id_z  = ids[2];

    p_done_le_total_r13: assert property (@(posedge clk) disable iff (rst)
        running |-> (wg_done_cnt <= wg_cnt_total));

    p_accept_clears_r9: assert property (@(posedge clk) disable iff (rst)
        accept |=> (wg_global == '0 && wg_done_cnt == '0 && !grid_done));

    p_vreg_nonzero_r1: assert property (@(posedge clk) disable iff (rst)
        running |-> (vreg_count != '0));

    p_err_idle_r12: assert property (@(posedge clk) disable iff (rst)
        cfg_error |-> !running);

    p_busy_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (running && !desc_ready) |=> $stable(wg_cnt_x));
endmodule

// File: tb/wgd_sequencer_tb_top.sv
module wgd_sequencer_tb_top;
    typedef struct packed {
        logic [31:0] gx, gy, gz, wx, wy, wz;
        logic [15:0] ev, es;
        logic [5:0]  vg;
        logic [3:0]  sg;
        logic        ng;
        logic [7:0]  mj;
        logic [15:0] xv, xs;
        logic        xe;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t TBL [NV] = '{
        '{32'd8,  32'd4, 32'd2, 32'd4, 32'd2, 32'd1, 16'd0,  16'd0,      6'd3, 4'd2, 1'b1, 8'd9, 16'd32, 16'd24, 1'b0},
        '{32'd10, 32'd3, 32'd1, 32'd4, 32'd2, 32'd1, 16'd20, 16'hFFFF,   6'd0, 4'd1, 1'b0, 8'd8, 16'd20, 16'd16, 1'b0},
        '{32'd5,  32'd1, 32'd1, 32'd8, 32'd1, 32'd1, 16'd0,  16'd12,     6'd5, 4'd0, 1'b0, 8'd0, 16'd24, 16'd12, 1'b0},
        '{32'd6,  32'd6, 32'd1, 32'd3, 32'd3, 32'd1, 16'd0,  16'd0,      6'd0, 4'd0, 1'b0, 8'd0, 16'd4,  16'd8,  1'b0},
        '{32'd4,  32'd1, 32'd1, 32'd1, 32'd1, 32'd1, 16'd7,  16'd7,      6'd0, 4'd0, 1'b0, 8'd7, 16'd0,  16'd0,  1'b1},
        '{32'd4,  32'd4, 32'd1, 32'd1, 32'd0, 32'd1, 16'd7,  16'd7,      6'd0, 4'd0, 1'b0, 8'd9, 16'd0,  16'd0,  1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        desc_valid = 1'b0;
    logic        desc_ready;
    logic [31:0] gx = '0, gy = '0, gz = '0, wx = '0, wy = '0, wz = '0;
    logic [15:0] ev = '0, es = '0;
    logic [5:0]  vg = '0;
    logic [3:0]  sg = '0;
    logic        ng = 1'b0;
    logic [7:0]  mj = '0;
    logic        disp_strobe = 1'b0;
    logic        done_strobe = 1'b0;
    logic [15:0] vreg_count, sreg_count;
    logic [31:0] cnt_x, cnt_y, cnt_z, cnt_t, id_x, id_y, id_z, gid, done_cnt;
    logic        grid_done, cfg_error;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    wgd_sequencer dut_i (
        .clk(clk), .rst(rst), .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_grid_x(gx), .desc_grid_y(gy), .desc_grid_z(gz),
        .desc_wg_x(wx), .desc_wg_y(wy), .desc_wg_z(wz),
        .desc_vreg(ev), .desc_sreg(es), .desc_vgran(vg), .desc_sgran(sg),
        .desc_newgen(ng), .desc_major(mj),
        .disp_strobe(disp_strobe), .done_strobe(done_strobe),
        .vreg_count(vreg_count), .sreg_count(sreg_count),
        .wg_cnt_x(cnt_x), .wg_cnt_y(cnt_y), .wg_cnt_z(cnt_z), .wg_cnt_total(cnt_t),
        .wg_id_x(id_x), .wg_id_y(id_y), .wg_id_z(id_z), .wg_global(gid),
        .wg_done_cnt(done_cnt), .grid_done(grid_done), .cfg_error(cfg_error)
    );

    function automatic logic [31:0] cdiv(input logic [31:0] a, input logic [31:0] b);
        if (a == 0 || b == 0) return 0;
        return (a + b - 1) / b;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load(input vec_t v);
        gx = v.gx; gy = v.gy; gz = v.gz; wx = v.wx; wy = v.wy; wz = v.wz;
        ev = v.ev; es = v.es; vg = v.vg; sg = v.sg; ng = v.ng; mj = v.mj;
    endtask

    task automatic offer(input vec_t v);
        load(v);
        desc_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        desc_valid = 1'b0;
    endtask

    task automatic pulse_disp();
        disp_strobe = 1'b1;
        @(posedge clk);
        @(negedge clk);
        disp_strobe = 1'b0;
    endtask

    task automatic pulse_done();
        done_strobe = 1'b1;
        @(posedge clk);
        @(negedge clk);
        done_strobe = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R9 reset ready", desc_ready, 1);
        check("R9 reset gid", gid, 0);
        check("R8 reset done", grid_done, 0);
        check("R12 reset err", cfg_error, 0);

        for (int k = 0; k < NV; k++) begin
            vec_t v;
            logic [31:0] nx, ny, nz, nt;
            v  = TBL[k];
            nx = cdiv(v.gx, v.wx);
            ny = cdiv(v.gy, v.wy);
            nz = cdiv(v.gz, v.wz);
            nt = nx * ny * nz;
            offer(v);
            if (v.xe) begin
                check("R4/R12 error flag", cfg_error, 1);
                check("R12 ready after refuse", desc_ready, 1);
                pulse_disp();
                check("R10 idle strobe gid", gid, 0);
                check("R10 idle strobe x", id_x, 0);
            end else begin
                check("R12 err clear", cfg_error, 0);
                check("R1 vreg", vreg_count, v.xv);
                check("R2/R3 sreg", sreg_count, v.xs);
                check("R5 cnt x", cnt_x, nx);
                check("R5 cnt y", cnt_y, ny);
                check("R5 cnt z", cnt_z, nz);
                check("R5 total", cnt_t, nt);
                check("R11 ready low", desc_ready, 0);
                for (int i = 0; i < nt; i++) begin
                    check("R6 gid", gid, i);
                    check("R7 x", id_x, i % nx);
                    check("R7 y", id_y, (i / nx) % ny);
                    check("R7 z", id_z, i / (nx * ny));
                    check("R8 not done", grid_done, 0);
                    pulse_disp();
                end
                check("R8 done", grid_done, 1);
                check("R8 final gid", gid, nt);
                check("R8 final x", id_x, 0);
                check("R8 final y", id_y, 0);
                check("R8 final z", id_z, nz);
                pulse_disp();
                check("R10 frozen gid", gid, nt);
                check("R10 frozen z", id_z, nz);
                for (int i = 0; i < nt; i++) begin
                    check("R11 ready held", desc_ready, 0);
                    pulse_done();
                end
                check("R13 done count", done_cnt, nt);
                check("R11 ready back", desc_ready, 1);
                pulse_done();
                check("R13 saturate", done_cnt, nt);
            end
        end

        offer(TBL[0]);
        pulse_disp();
        pulse_disp();
        pulse_disp();
        offer(TBL[1]);
        check("R11 busy ignore cnt x", cnt_x, 2);
        check("R11 busy ignore vreg", vreg_count, 32);
        check("R11 busy ignore gid", gid, 3);
        check("R6 partial x", id_x, 1);
        check("R7 partial y", id_y, 1);
        for (int i = 0; i < 8; i++) pulse_done();
        check("R13 early done count", done_cnt, 8);
        check("R11 ready on count", desc_ready, 1);
        offer(TBL[3]);
        check("R9 restart gid", gid, 0);
        check("R9 restart x", id_x, 0);
        check("R9 restart y", id_y, 0);
        check("R9 restart done", done_cnt, 0);
        check("R5 restart cnt x", cnt_x, 2);

        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R9 reset ready again", desc_ready, 1);
        check("R9 reset gid again", gid, 0);
        summary();
    end
endmodule